// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the two low address bits for a four-beat burst. When a burst opens, the two least-significant bits of the captured address are loaded as the seed. Each advance request then steps the output to the next beat address. The output wraps back to the seed after the fourth beat.

The wrap order is chosen at load time by a single mode input. A driven logic 0 selects a sequential order: the seed plus the beat count, modulo four. Any other level selects an interleaved order: the seed XOR the beat count. A floating or unknown level counts as "any other level", so an unconnected mode pin behaves as if it were pulled high.

The upper address bits, the storage array and the byte-strobe decoding are handled by neighbouring logic. That logic reads only the registered two-bit beat address from this block.

Top module: `bsq_burst_seq`

## Requirements
- R1: While reset is asserted (active low, asynchronous), the beat address output is 2'b00.
- R2: A load at a clock edge makes the output equal to the seed bits on that edge from the next cycle, and restarts the beat count at 0.
- R3: With the order latched as sequential (mode driven 0 at load), the output after n advances since load is (seed + n) mod 4. For example, seed 01 gives 01, 10, 11, 00.
- R4: With the order latched as interleaved (mode at any level other than a driven 0 at load, including high or floating), the output after n advances is seed XOR n. For example, seed 01 gives 01, 00, 11, 10.
- R5: After four advances the output returns to the seed value, and further advances repeat the same four-beat cycle.
- R6: When load and advance are both high at one edge, the load wins: the next output is the new seed, not a stepped value.
- R7: With neither load nor advance high, the output holds its value.
- R8: The mode input is sampled only on a load. Changing mode during a burst has no effect on the order of the remaining beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a burst from seed_i |
| seed_i | input | 2 | Low two bits of the captured burst start address |
| adv_i | input | 1 | Step to the next beat address |
| mode_i | input | 1 | Order select at load: 0 sequential, otherwise interleaved |
| addr_o | output | 2 | Current beat address |

## Verification
A table-driven run opens bursts from several seeds in both orders and walks each one past its wrap point. A seed such as 01 or 11 gives different second and fourth beats in the two orders, so those seeds tell an adder-based step from an XOR-based one. Seed 00 gives the same sequence in both orders, so it is not relied on to tell them apart. Further table rows assert load together with advance, leave both idle, and flip mode in the middle of a burst; these separate load priority, holding and order latching from plain stepping. Directed loops then sweep every seed in both orders using the bench's own arithmetic, and a reset applied mid-burst confirms the output clears.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  localparam int unsigned BEAT_W = 2;
  localparam int unsigned BEATS  = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  // sequential order: seed advanced by beat count, wrapping at BEATS
  function automatic beat_t seq_addr(input beat_t seed, input beat_t idx);
    beat_t sum;
    sum = beat_t'(seed + idx);
    return sum;
  endfunction

  // interleaved order: beat count toggles the seed bits
  function automatic beat_t ilv_addr(input beat_t seed, input beat_t idx);
    return seed ^ idx;
  endfunction

  function automatic beat_t beat_addr(input beat_t seed, input beat_t idx, input order_e ord);
    beat_t res;
    if (ord == ORD_SEQ) res = seq_addr(seed, idx);
    else                res = ilv_addr(seed, idx);
    return res;
  endfunction

  // anything other than a firmly driven 0 selects interleaved order
  function automatic order_e resolve_mode(input logic mode_raw);
    order_e ord;
    if (mode_raw === 1'b0) ord = ORD_SEQ;
    else                   ord = ORD_ILV;
    return ord;
  endfunction

endpackage

// File: rtl/bsq_order_latch.sv
module bsq_order_latch
  import bsq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  logic   mode_i,
  output order_e order_o
);

  order_e order_q;
  order_e order_in;

  assign order_in = resolve_mode(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     order_q <= ORD_ILV;
    else if (load_i) order_q <= order_in;
  end

  assign order_o = order_q;

endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import bsq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  adv_i,
  input  beat_t seed_i,
  output beat_t seed_o,
  output beat_t beat_o,
  output logic  step_o
);

  beat_t seed_q;
  beat_t beat_q;
  logic  step;

  // load has priority over advance
  assign step = adv_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      seed_q <= seed_i;
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_t'(beat_q + beat_t'(1));
    end
  end

  assign seed_o = seed_q;
  assign beat_o = beat_q;
  assign step_o = step;

endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen
  import bsq_pkg::*;
(
  input  beat_t  seed_i,
  input  beat_t  beat_i,
  input  order_e order_i,
  output beat_t  addr_o
);

  assign addr_o = beat_addr(seed_i, beat_i, order_i);

endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq
  import bsq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] seed_i,
  input  logic              adv_i,
  input  logic              mode_i,
  output logic [BEAT_W-1:0] addr_o
);

  // named internal events, observed by the bound checker
  order_e order_q;
  beat_t  seed_q;
  beat_t  beat_q;
  logic   step_evt;

  bsq_order_latch u_order (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .mode_i  (mode_i),
    .order_o (order_q)
  );

  bsq_beat_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_i  (adv_i),
    .seed_i (seed_i),
    .seed_o (seed_q),
    .beat_o (beat_q),
    .step_o (step_evt)
  );

  bsq_addr_gen u_gen (
    .seed_i  (seed_q),
    .beat_i  (beat_q),
    .order_i (order_q),
    .addr_o  (addr_o)
  );

endmodule

// File: rtl/bsq_burst_seq_chk.sv
module bsq_burst_seq_chk
  import bsq_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   load_i,
  input beat_t  seed_i,
  input logic   adv_i,
  input beat_t  addr_i,
  input order_e order_i,
  input beat_t  beat_i,
  input logic   step_i
);

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> addr_i == '0);

  p_load_seed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_i == $past(seed_i)) && (beat_i == '0));

  p_seq_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && order_i == ORD_SEQ) |=> addr_i == beat_t'($past(addr_i) + beat_t'(1)));

  p_ilv_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && order_i == ORD_ILV) |=>
      addr_i == ($past(addr_i) ^ $past(beat_i) ^ beat_t'($past(beat_i) + beat_t'(1))));

  p_load_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && adv_i) |=> addr_i == $past(seed_i));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(addr_i));

  p_order_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(order_i));

endmodule

bind bsq_burst_seq bsq_burst_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .seed_i  (seed_i),
  .adv_i   (adv_i),
  .addr_i  (addr_o),
  .order_i (order_q),
  .beat_i  (beat_q),
  .step_i  (step_evt)
);

// File: tb/bsq_burst_seq_tb.sv
module bsq_burst_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       load = 1'b0;
  logic [1:0] seed = 2'b00;
  logic       adv = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  bsq_burst_seq dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .load_i (load),
    .seed_i (seed),
    .adv_i  (adv),
    .mode_i (mode),
    .addr_o (addr)
  );

  // {req[3:0], load, adv, mode, seed[1:0], expected[1:0]}
  localparam int NV = 17;
  localparam logic [10:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b0, 1'b0, 2'd2, 2'd2}, // R2 seed 10, sequential
    {4'd3, 1'b0, 1'b1, 1'b0, 2'd0, 2'd3}, // R3
    {4'd3, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0}, // R3
    {4'd3, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1}, // R3
    {4'd5, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2}, // R5 back to seed
    {4'd2, 1'b1, 1'b0, 1'b1, 2'd1, 2'd1}, // R2 seed 01, interleaved
    {4'd4, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0}, // R4
    {4'd4, 1'b0, 1'b1, 1'b1, 2'd0, 2'd3}, // R4
    {4'd4, 1'b0, 1'b1, 1'b1, 2'd0, 2'd2}, // R4
    {4'd5, 1'b0, 1'b1, 1'b1, 2'd0, 2'd1}, // R5 back to seed
    {4'd7, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1}, // R7 idle holds
    {4'd6, 1'b1, 1'b1, 1'b1, 2'd3, 2'd3}, // R6 load beats advance
    {4'd8, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2}, // R8 mode flip ignored: 11^1
    {4'd8, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1}, // R8 11^2
    {4'd2, 1'b1, 1'b0, 1'b0, 2'd3, 2'd3}, // R2 seed 11, sequential
    {4'd3, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0}, // R3 wrap 11->00
    {4'd3, 1'b0, 1'b1, 1'b1, 2'd0, 2'd1}  // R3
  };

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: addr=%0d expected=%0d", req, got, exp);
    end
  endtask

  // drive at falling edge, result of the next rising edge is sampled at the following falling edge
  task automatic step_cycle(input logic l, input logic a, input logic m, input logic [1:0] s);
    load = l; adv = a; mode = m; seed = s;
    @(negedge clk);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", addr, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", addr, 2'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      step_cycle(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:2]);
      check($sformatf("R%0d", VEC[i][10:7]), addr, VEC[i][1:0]);
    end

    // directed sweeps: every seed, both orders, five advances
    for (int s = 0; s < 4; s++) begin
      step_cycle(1'b1, 1'b0, 1'b0, 2'(s));
      check("R2", addr, 2'(s));
      for (int n = 1; n <= 5; n++) begin
        step_cycle(1'b0, 1'b1, 1'b0, 2'd0);
        check(n == 4 ? "R5" : "R3", addr, 2'((s + n) % 4));
      end
      step_cycle(1'b1, 1'b0, 1'b1, 2'(s));
      check("R2", addr, 2'(s));
      for (int n = 1; n <= 5; n++) begin
        step_cycle(1'b0, 1'b1, 1'b1, 2'd0);
        check(n == 4 ? "R5" : "R4", addr, 2'(s) ^ 2'(n % 4));
      end
    end

    // idle over several cycles
    step_cycle(1'b1, 1'b0, 1'b0, 2'd1);
    step_cycle(1'b0, 1'b1, 1'b0, 2'd0);
    for (int k = 0; k < 3; k++) begin
      step_cycle(1'b0, 1'b0, 1'b1, 2'd3);
      check("R7", addr, 2'd2);
    end

    // reset in the middle of a burst
    step_cycle(1'b0, 1'b1, 1'b0, 2'd0);
    #3 rst_n = 1'b0;
    #2 check("R1", addr, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", addr, 2'd0);

    load = 1'b0; adv = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule